// File: doc/BRIEF.md
# DRAM Operating-Point Change Sequencer

This block is a hardware state machine that moves a DRAM controller from one operating point to another without software stepping through the procedure. When it receives a start command with a target point index, it quiesces traffic and puts the memory into self-refresh. It then runs a PHY re-initialization handshake around a clock switch and waits out a guard interval. After that it releases self-refresh, replays the per-rank mode-register writes for the new point and re-opens the controller to traffic.

Every step is gated by a status input: port-busy flags, queue-empty flags, the 6-bit operating-mode word, PHY init-complete, clock-switch done, mode-register write done and the software-done acknowledgement. The outputs are level controls for the controller (port enable, command block, self-refresh request, point select, refresh-level toggle, PHY init start, clock-switch request), a one-at-a-time mode-register write request, and a busy/done pair. The guard interval is a cycle count taken from an input, so it can be made long in silicon and short in simulation.

Top module: `dram_opchange_seq`

## Requirements
- R1: Out of reset the block is idle: `busy`, `done`, `cmd_block`, `selfref_req`, `freq_chg`, `refresh_lvl`, `phy_init_start`, `clk_switch_req` and `mr_req` are 0, and `sw_done` and `port_en` are 1.
- R2: A start drops `sw_done` first and then `port_en`. `cmd_block` rises only after both port-busy inputs were sampled low. `selfref_req` rises only after both queue-empty inputs were sampled high.
- R3: When `op_mode` is sampled equal to 6'h23 during entry, `point_sel` takes the target index, `freq_chg` rises and `refresh_lvl` inverts. `refresh_lvl` changes exactly once per operating-point change.
- R4: `phy_init_start` rises after `freq_chg`. `clk_switch_req` rises only after `phy_init_done` was sampled low. `phy_init_start` and `clk_switch_req` fall together once `clk_switch_done` is sampled high.
- R5: `selfref_req` falls exactly `guard_cycles`+1 clock edges after the edge that first samples `phy_init_done` high following the fall of `phy_init_start`.
- R6: Mode-register writes begin only once `op_mode` is sampled different from 6'h23. For each rank from 1 to `num_ranks`, the writes have address 0..6 in rising order, with `mr_tbl_idx` equal to the address for 0..5 and equal to 7 for address 6. That gives 7×`num_ranks` writes.
- R7: `mr_req` stays high with stable `mr_rank`/`mr_addr` until `mr_done` is sampled, drops on the next edge, and the next write is not raised before one full low cycle.
- R8: After the last write, `cmd_block` falls while `port_en` and `sw_done` rise. `done` pulses for one cycle after `sw_done_ack` is sampled high, and `busy` is already low during that pulse.
- R9: `busy` is high from the accepted start until completion. A start that arrives while busy has no effect on `point_sel` and does not add a second run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start an operating-point change (accepted when idle) |
| target_pt | input | PT_W | Target operating-point index |
| num_ranks | input | RANK_W | Number of ranks to replay mode registers for |
| guard_cycles | input | GUARD_W | Guard interval length in cycles |
| rd_port_busy | input | 1 | Read ports still have traffic |
| wr_port_busy | input | 1 | Write ports still have traffic |
| rdq_empty | input | 1 | Read queue empty |
| wrq_empty | input | 1 | Write queue empty |
| op_mode | input | 6 | Controller operating-mode status (6'h23 = in self-refresh) |
| phy_init_done | input | 1 | PHY init-complete status |
| clk_switch_done | input | 1 | Clock switch finished |
| mr_done | input | 1 | Mode-register write finished |
| sw_done_ack | input | 1 | Acknowledge of the software-done flag |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sw_done | output | 1 | Software-done flag to the controller |
| port_en | output | 1 | Host ports enabled |
| cmd_block | output | 1 | Block new host commands |
| selfref_req | output | 1 | Self-refresh request |
| point_sel | output | PT_W | Selected operating point |
| freq_chg | output | 1 | Frequency-change flag |
| refresh_lvl | output | 1 | Refresh-update level (toggled per change) |
| phy_init_start | output | 1 | PHY init start |
| clk_switch_req | output | 1 | Request the clock switch |
| mr_req | output | 1 | Mode-register write request |
| mr_rank | output | RANK_W | Rank of the current write |
| mr_addr | output | 3 | Mode-register address |
| mr_tbl_idx | output | 3 | Table entry supplying the write data |

## Verification
The hardest situations to reach from the ports are the waits that only a slow environment exposes. Examples are a transitional operating mode (6'h03) that has the low two bits set but is not self-refresh, a write request left hanging for several cycles, and a PHY that drops init-complete late. The bench therefore wraps the block in a reactive model whose every status reply comes after a programmable latency. It sweeps that latency, the rank count, the target point and the guard length. At each output transition it checks that the gating input had the required value one edge earlier, and it measures the guard window in edges.

// File: rtl/dfc_pkg.sv
// Shared state encoding and fixed constants for the operating-point change
// sequencer. Assumes a 6-bit operating-mode status word.
package dfc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PORTS_OFF,
        ST_WAIT_PORTS,
        ST_WAIT_QUEUES,
        ST_WAIT_SR,
        ST_PHY_START,
        ST_WAIT_INIT_LOW,
        ST_CLK_SWITCH,
        ST_WAIT_INIT_HIGH,
        ST_GUARD,
        ST_WAIT_SR_EXIT,
        ST_MR_REPLAY,
        ST_WAIT_ACK
    } seq_state_t;

    localparam logic [5:0] OPMODE_SELFREF = 6'h23;
    localparam logic [2:0] MR_LAST_ADDR   = 3'd6;
    localparam logic [2:0] MR_LAST_IDX    = 3'd7;

endpackage

// File: rtl/dfc_guard_timer.sv
// Guard-interval down-counter. Loaded with a cycle count on `load`; while
// `run` is high it counts down and reports `expired` once it reaches zero.
// Assumes `load` and `run` are never high in the same cycle.
module dfc_guard_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Load the interval, then decrement toward zero while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Interval over when running with nothing left to count.
    always_comb expired = run && (cnt == '0);

endmodule

// File: rtl/dfc_mr_replay.sv
// Mode-register replay engine. On `kick` it walks ranks 1..num_ranks and,
// per rank, addresses 0..6, issuing one request at a time and waiting for
// `mr_done` before the next. Address 6 reads table entry 7. Pulses
// `finished` after the last write completes. A rank count of 0 acts as 1.
module dfc_mr_replay
    import dfc_pkg::*;
#(
    parameter int RANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic [RANK_W-1:0] num_ranks,
    input  logic              mr_done,
    output logic              mr_req,
    output logic [RANK_W-1:0] mr_rank,
    output logic [2:0]        mr_addr,
    output logic [2:0]        mr_tbl_idx,
    output logic              finished
);

    logic active;
    logic last_write;

    // Final write: top address of the last rank.
    always_comb last_write = (mr_addr == MR_LAST_ADDR) && (mr_rank >= num_ranks);

    // Table entry: address itself, except the last address maps to entry 7.
    always_comb mr_tbl_idx = (mr_addr == MR_LAST_ADDR) ? MR_LAST_IDX : mr_addr;

    // Walk the rank/address sequence with a single outstanding request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            mr_req   <= 1'b0;
            mr_rank  <= '0;
            mr_addr  <= '0;
            finished <= 1'b0;
        end else begin
            finished <= 1'b0;
            if (kick) begin
                active  <= 1'b1;
                mr_req  <= 1'b1;
                mr_rank <= RANK_W'(1);
                mr_addr <= '0;
            end else if (active) begin
                if (mr_req) begin
                    if (mr_done) begin
                        mr_req <= 1'b0;
                        if (last_write) begin
                            active   <= 1'b0;
                            finished <= 1'b1;
                        end else if (mr_addr == MR_LAST_ADDR) begin
                            mr_addr <= '0;
                            mr_rank <= mr_rank + 1'b1;
                        end else begin
                            mr_addr <= mr_addr + 1'b1;
                        end
                    end
                end else begin
                    mr_req <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dram_opchange_seq.sv
// Operating-point change sequencer. Runs quiesce, self-refresh entry, PHY
// re-init around a clock switch, a guard wait, self-refresh exit, per-rank
// mode-register replay and traffic re-enable, each step gated by a status
// input. Assumes status inputs are synchronous to clk.
module dram_opchange_seq
    import dfc_pkg::*;
#(
    parameter int PT_W    = 2,
    parameter int RANK_W  = 2,
    parameter int GUARD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PT_W-1:0]    target_pt,
    input  logic [RANK_W-1:0]  num_ranks,
    input  logic [GUARD_W-1:0] guard_cycles,
    input  logic               rd_port_busy,
    input  logic               wr_port_busy,
    input  logic               rdq_empty,
    input  logic               wrq_empty,
    input  logic [5:0]         op_mode,
    input  logic               phy_init_done,
    input  logic               clk_switch_done,
    input  logic               mr_done,
    input  logic               sw_done_ack,
    output logic               busy,
    output logic               done,
    output logic               sw_done,
    output logic               port_en,
    output logic               cmd_block,
    output logic               selfref_req,
    output logic [PT_W-1:0]    point_sel,
    output logic               freq_chg,
    output logic               refresh_lvl,
    output logic               phy_init_start,
    output logic               clk_switch_req,
    output logic               mr_req,
    output logic [RANK_W-1:0]  mr_rank,
    output logic [2:0]         mr_addr,
    output logic [2:0]         mr_tbl_idx
);

    seq_state_t      state;
    logic [PT_W-1:0] tgt_q;
    logic            guard_load;
    logic            guard_run;
    logic            guard_expired;
    logic            mr_kick;
    logic            mr_finished;

    // Busy whenever the sequencer is away from idle.
    always_comb busy = (state != ST_IDLE);

    // Guard starts on the edge that sees init-complete return high.
    always_comb guard_load = (state == ST_WAIT_INIT_HIGH) && phy_init_done;
    always_comb guard_run  = (state == ST_GUARD);

    // Replay starts once the controller has left self-refresh.
    always_comb mr_kick = (state == ST_WAIT_SR_EXIT) && (op_mode != OPMODE_SELFREF);

    dfc_guard_timer #(.W(GUARD_W)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (guard_load),
        .load_val (guard_cycles),
        .run      (guard_run),
        .expired  (guard_expired)
    );

    dfc_mr_replay #(.RANK_W(RANK_W)) u_replay (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick       (mr_kick),
        .num_ranks  (num_ranks),
        .mr_done    (mr_done),
        .mr_req     (mr_req),
        .mr_rank    (mr_rank),
        .mr_addr    (mr_addr),
        .mr_tbl_idx (mr_tbl_idx),
        .finished   (mr_finished)
    );

    // Main step sequencer with status-gated transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= ST_IDLE;
            tgt_q          <= '0;
            done           <= 1'b0;
            sw_done        <= 1'b1;
            port_en        <= 1'b1;
            cmd_block      <= 1'b0;
            selfref_req    <= 1'b0;
            point_sel      <= '0;
            freq_chg       <= 1'b0;
            refresh_lvl    <= 1'b0;
            phy_init_start <= 1'b0;
            clk_switch_req <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    tgt_q    <= target_pt;
                    sw_done  <= 1'b0;
                    freq_chg <= 1'b0;
                    state    <= ST_PORTS_OFF;
                end
                ST_PORTS_OFF: begin
                    port_en <= 1'b0;
                    state   <= ST_WAIT_PORTS;
                end
                ST_WAIT_PORTS: if (!rd_port_busy && !wr_port_busy) begin
                    cmd_block <= 1'b1;
                    state     <= ST_WAIT_QUEUES;
                end
                ST_WAIT_QUEUES: if (rdq_empty && wrq_empty) begin
                    selfref_req <= 1'b1;
                    state       <= ST_WAIT_SR;
                end
                ST_WAIT_SR: if (op_mode == OPMODE_SELFREF) begin
                    point_sel   <= tgt_q;
                    freq_chg    <= 1'b1;
                    refresh_lvl <= ~refresh_lvl;
                    state       <= ST_PHY_START;
                end
                ST_PHY_START: begin
                    phy_init_start <= 1'b1;
                    state          <= ST_WAIT_INIT_LOW;
                end
                ST_WAIT_INIT_LOW: if (!phy_init_done) begin
                    clk_switch_req <= 1'b1;
                    state          <= ST_CLK_SWITCH;
                end
                ST_CLK_SWITCH: if (clk_switch_done) begin
                    clk_switch_req <= 1'b0;
                    phy_init_start <= 1'b0;
                    state          <= ST_WAIT_INIT_HIGH;
                end
                ST_WAIT_INIT_HIGH: if (phy_init_done) begin
                    state <= ST_GUARD;
                end
                ST_GUARD: if (guard_expired) begin
                    selfref_req <= 1'b0;
                    state       <= ST_WAIT_SR_EXIT;
                end
                ST_WAIT_SR_EXIT: if (mr_kick) begin
                    state <= ST_MR_REPLAY;
                end
                ST_MR_REPLAY: if (mr_finished) begin
                    cmd_block <= 1'b0;
                    port_en   <= 1'b1;
                    sw_done   <= 1'b1;
                    state     <= ST_WAIT_ACK;
                end
                ST_WAIT_ACK: if (sw_done_ack) begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dfc_checker.sv
// Protocol checker for the operating-point change sequencer: each output
// transition is related to the gating status seen one edge before.
module dfc_checker #(
    parameter int RANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_port_busy,
    input logic              wr_port_busy,
    input logic              rdq_empty,
    input logic              wrq_empty,
    input logic [5:0]        op_mode,
    input logic              phy_init_done,
    input logic              mr_done,
    input logic              sw_done_ack,
    input logic              busy,
    input logic              done,
    input logic              cmd_block,
    input logic              selfref_req,
    input logic              freq_chg,
    input logic              clk_switch_req,
    input logic              mr_req,
    input logic [RANK_W-1:0] mr_rank,
    input logic [2:0]        mr_addr
);

    assert_cmd_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_block) |-> $past(!rd_port_busy && !wr_port_busy));

    assert_sr_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selfref_req) |-> $past(rdq_empty && wrq_empty));

    assert_point_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freq_chg) |-> $past(op_mode == 6'h23));

    assert_switch_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_switch_req) |-> $past(!phy_init_done));

    assert_mr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_req && !mr_done) |=> (mr_req && $stable(mr_addr) && $stable(mr_rank)));

    assert_mr_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_req && mr_done) |=> !mr_req);

    assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(sw_done_ack) && !busy));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mr_req && !clk_switch_req && !selfref_req && !cmd_block));

endmodule

bind dram_opchange_seq dfc_checker #(.RANK_W(RANK_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_port_busy   (rd_port_busy),
    .wr_port_busy   (wr_port_busy),
    .rdq_empty      (rdq_empty),
    .wrq_empty      (wrq_empty),
    .op_mode        (op_mode),
    .phy_init_done  (phy_init_done),
    .mr_done        (mr_done),
    .sw_done_ack    (sw_done_ack),
    .busy           (busy),
    .done           (done),
    .cmd_block      (cmd_block),
    .selfref_req    (selfref_req),
    .freq_chg       (freq_chg),
    .clk_switch_req (clk_switch_req),
    .mr_req         (mr_req),
    .mr_rank        (mr_rank),
    .mr_addr        (mr_addr)
);

// File: tb/sim_dram_opchange_seq.sv
module sim_dram_opchange_seq;

    localparam int PT_W = 2;
    localparam int RANK_W = 2;
    localparam int GUARD_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [PT_W-1:0] target_pt = '0;
    logic [RANK_W-1:0] num_ranks = RANK_W'(1);
    logic [GUARD_W-1:0] guard_cycles = '0;
    logic rd_port_busy = 1'b1, wr_port_busy = 1'b1;
    logic rdq_empty = 1'b0, wrq_empty = 1'b0;
    logic [5:0] op_mode = 6'h01;
    logic phy_init_done = 1'b1, clk_switch_done = 1'b0;
    logic mr_done = 1'b0, sw_done_ack = 1'b1;
    logic busy, done, sw_done, port_en, cmd_block, selfref_req, freq_chg;
    logic refresh_lvl, phy_init_start, clk_switch_req, mr_req;
    logic [PT_W-1:0] point_sel;
    logic [RANK_W-1:0] mr_rank;
    logic [2:0] mr_addr, mr_tbl_idx;

    int n_chk = 0, n_fail = 0;
    int dly = 0, cur_nr = 1, cur_g = 0, cur_tgt = 0;
    int mr_cnt = 0, done_cnt = 0, g_cnt = 0;
    bit g_on = 0, run_act = 0, exp_lvl = 0;
    int cp = 0, cq = 0, cs = 0, ci = 0, cc = 0, cm = 0, ca = 0;

    always #5 clk = ~clk;

    dram_opchange_seq #(.PT_W(PT_W), .RANK_W(RANK_W), .GUARD_W(GUARD_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .target_pt(target_pt),
        .num_ranks(num_ranks), .guard_cycles(guard_cycles),
        .rd_port_busy(rd_port_busy), .wr_port_busy(wr_port_busy),
        .rdq_empty(rdq_empty), .wrq_empty(wrq_empty), .op_mode(op_mode),
        .phy_init_done(phy_init_done), .clk_switch_done(clk_switch_done),
        .mr_done(mr_done), .sw_done_ack(sw_done_ack), .busy(busy), .done(done),
        .sw_done(sw_done), .port_en(port_en), .cmd_block(cmd_block),
        .selfref_req(selfref_req), .point_sel(point_sel), .freq_chg(freq_chg),
        .refresh_lvl(refresh_lvl), .phy_init_start(phy_init_start),
        .clk_switch_req(clk_switch_req), .mr_req(mr_req), .mr_rank(mr_rank),
        .mr_addr(mr_addr), .mr_tbl_idx(mr_tbl_idx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Environment model and transition monitor, both at the falling edge.
    initial begin
        logic p_sw, p_pe, p_cb, p_sr, p_fc, p_pi, p_cs, p_mr, p_dn;
        p_sw = 1; p_pe = 1; p_cb = 0; p_sr = 0; p_fc = 0; p_pi = 0; p_cs = 0; p_mr = 0; p_dn = 0;
        forever begin
            @(negedge clk);
            if (run_act) begin
                if (p_sw && !sw_done) chk(port_en, "R2 port_en at sw_done fall", port_en, 1);
                if (p_pe && !port_en) chk(!sw_done, "R2 sw_done at port_en fall", sw_done, 0);
                if (!p_cb && cmd_block)
                    chk(!rd_port_busy && !wr_port_busy && !port_en, "R2 cmd_block gate",
                        {rd_port_busy, wr_port_busy}, 0);
                if (!p_sr && selfref_req)
                    chk(rdq_empty && wrq_empty && cmd_block, "R2 self-refresh gate",
                        {rdq_empty, wrq_empty}, 3);
                if (!p_fc && freq_chg) begin
                    chk(op_mode == 6'h23, "R3 op_mode at point load", op_mode, 6'h23);
                    chk(int'(point_sel) == cur_tgt, "R3 point_sel", point_sel, cur_tgt);
                    chk(refresh_lvl == exp_lvl, "R3 refresh_lvl toggle", refresh_lvl, exp_lvl);
                end
                if (!p_pi && phy_init_start) chk(freq_chg, "R4 init start after point", freq_chg, 1);
                if (!p_cs && clk_switch_req)
                    chk(!phy_init_done && phy_init_start, "R4 switch gate", phy_init_done, 0);
                if (p_pi && !phy_init_start)
                    chk(clk_switch_done && !clk_switch_req, "R4 init start drop", clk_switch_done, 1);
                if (g_on) begin
                    g_cnt++;
                    if (!selfref_req) begin
                        chk(g_cnt == cur_g + 2, "R5 guard length", g_cnt, cur_g + 2);
                        g_on = 0;
                    end
                end
                if (!p_mr && mr_req) begin
                    if (mr_cnt == 0)
                        chk(op_mode != 6'h23 && !selfref_req, "R6 replay after exit", op_mode, 1);
                    chk(int'(mr_rank) == mr_cnt / 7 + 1, "R6 rank", mr_rank, mr_cnt / 7 + 1);
                    chk(int'(mr_addr) == mr_cnt % 7, "R6 address", mr_addr, mr_cnt % 7);
                    chk(int'(mr_tbl_idx) == ((mr_cnt % 7 == 6) ? 7 : mr_cnt % 7), "R6 table index",
                        mr_tbl_idx, (mr_cnt % 7 == 6) ? 7 : mr_cnt % 7);
                    chk(!mr_done, "R7 new request with done low", mr_done, 0);
                    mr_cnt++;
                end
                if (p_mr && !mr_req) chk(mr_done, "R7 request drop after done", mr_done, 1);
                if (p_cb && !cmd_block) begin
                    chk(port_en && sw_done, "R8 reopen", {port_en, sw_done}, 3);
                    chk(mr_cnt == 7 * cur_nr, "R8 writes before reopen", mr_cnt, 7 * cur_nr);
                end
                if (!p_dn && done) begin
                    chk(sw_done_ack && !busy, "R8 done gate", {sw_done_ack, busy}, 2);
                    done_cnt++;
                end
            end
            p_sw = sw_done; p_pe = port_en; p_cb = cmd_block; p_sr = selfref_req; p_fc = freq_chg;
            p_pi = phy_init_start; p_cs = clk_switch_req; p_mr = mr_req; p_dn = done;

            // Ports drain a set time after disable; write side one cycle later.
            if (port_en) cp = 0; else if (cp < 1000) cp++;
            rd_port_busy = port_en || (cp <= dly);
            wr_port_busy = port_en || (cp <= dly + 1);
            if (!cmd_block) cq = 0; else if (cq < 1000) cq++;
            rdq_empty = cmd_block && (cq > dly + 1);
            wrq_empty = cmd_block && (cq > dly);
            if (selfref_req) begin
                if (op_mode != 6'h23) begin
                    if (cs >= dly) begin op_mode = 6'h23; cs = 0; end
                    else begin op_mode = 6'h03; cs++; end
                end
            end else if (op_mode != 6'h01) begin
                if (cs >= dly) begin op_mode = 6'h01; cs = 0; end else cs++;
            end
            if (phy_init_start && phy_init_done) begin
                if (ci >= dly) begin phy_init_done = 0; ci = 0; end else ci++;
            end else if (!phy_init_start && !phy_init_done) begin
                if (ci >= dly) begin phy_init_done = 1; ci = 0; g_on = 1; g_cnt = 0; end else ci++;
            end
            if (!clk_switch_req) begin clk_switch_done = 0; cc = 0; end
            else if (!clk_switch_done) begin
                if (cc >= dly) clk_switch_done = 1; else cc++;
            end
            if (mr_done) begin mr_done = 0; cm = 0; end
            else if (mr_req) begin
                if (cm >= dly + 1) mr_done = 1; else cm++;
            end
            if (!sw_done) begin sw_done_ack = 0; ca = 0; end
            else if (!sw_done_ack) begin
                if (ca >= dly) sw_done_ack = 1; else ca++;
            end
        end
    end

    task automatic run_one(input int nr, input int tgt, input int g, input int d);
        int to;
        num_ranks = RANK_W'(nr); guard_cycles = GUARD_W'(g); dly = d;
        cur_nr = nr; cur_g = g; cur_tgt = tgt;
        mr_cnt = 0; done_cnt = 0; g_on = 0;
        exp_lvl = ~exp_lvl;
        @(negedge clk);
        start = 1; target_pt = PT_W'(tgt); run_act = 1;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        chk(busy, "R9 busy during run", busy, 1);
        start = 1; target_pt = PT_W'(~tgt);
        @(negedge clk);
        start = 0;
        to = 0;
        while (done_cnt == 0 && to < 5000) begin @(negedge clk); to++; end
        chk(to < 5000, "R8 completion reached", to, 0);
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R9 single completion", done_cnt, 1);
        chk(int'(point_sel) == tgt, "R9 late start ignored", point_sel, tgt);
        chk(mr_cnt == 7 * nr, "R6 write count", mr_cnt, 7 * nr);
        chk(!busy && sw_done && port_en && !cmd_block, "R8 final state",
            {busy, sw_done, port_en, cmd_block}, 6);
        chk(refresh_lvl == exp_lvl, "R3 one toggle per change", refresh_lvl, exp_lvl);
        run_act = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !cmd_block && !selfref_req && !freq_chg && !refresh_lvl,
            "R1 idle controls low", {busy, done, cmd_block, selfref_req, freq_chg, refresh_lvl}, 0);
        chk(!phy_init_start && !clk_switch_req && !mr_req, "R1 handshakes low",
            {phy_init_start, clk_switch_req, mr_req}, 0);
        chk(sw_done && port_en, "R1 sw_done and port_en high", {sw_done, port_en}, 3);
        for (int d = 0; d <= 2; d += 2)
            for (int g = 0; g <= 3; g += 3)
                for (int nr = 1; nr <= 3; nr++)
                    for (int t = 0; t < 4; t++)
                        run_one(nr, t, g, d);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule